// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer datapath of a small processor in which every transfer travels over one shared internal bus. The program counter, memory address register, memory data register, instruction register, three general registers, an operand latch (Y), an adder and a result register (Z) all hang off that bus. A separate controller, not part of this block, supplies one-bit strobes every cycle. The "out" strobes pick which register drives the bus, and the "in" strobes pick which registers capture the bus value at the next clock edge.

The adder always takes its first operand from Y and its second from the bus. When adding, its result is Y + bus + carry-in. Clearing the Y operand and setting carry-in while the program counter drives the bus gives PC+1, so incrementing the program counter needs no separate incrementer.

A memory port brings out the address register and the data register, passes the controller's read request through, and accepts returned data together with a completion strobe. The block carries out whatever strobe sequence it receives, such as an instruction fetch followed by a register-plus-memory add.

Top module: `sbus_datapath`

## Requirements
- R1: After reset all internal registers are zero. The outputs pc_o, ir_o, mem_addr_o and mem_mdr_o read zero, and bus_o reads zero while no out strobe is active.
- R2: The bus reads zero when no out strobe is active. When exactly one of pc_out, mdr_out, r_out[k] or z_out is active, bus_o equals the register it selects, in the same cycle. The controller activates at most one out strobe per cycle.
- R3: A register whose in strobe is high at a rising clock edge takes that cycle's bus value. The in strobes are pc_in, mar_in, ir_in, y_in and r_in[k]. A register whose in strobe is low keeps its value.
- R4: With add_en high and z_in high, Z takes Y + bus + cin (modulo 2^DW) at the clock edge. Y here is the latched Y value.
- R5: With clr_y high, the adder's first operand is zero. pc_out with cin, add_en and z_in therefore puts PC+1 into Z, and 16'hFFFF wraps to 0. Driving Z back into the PC with z_out and pc_in completes the increment.
- R6: With add_en low and z_in high, Z takes the bus value unchanged. Z keeps its value whenever z_in is low.
- R7: mem_rd_o follows the rd input in the same cycle. mem_addr_o always shows the address register, which changes only on mar_in.
- R8: The memory data register loads mem_rdata only at an edge where mem_done is high. A pending read with mem_done low leaves it unchanged. mem_mdr_o always shows its value.
- R9: If mem_done and mdr_in are both high at the same edge, the memory data wins over the bus value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | 1 | Program counter captures bus |
| pc_out | input | 1 | Program counter drives bus |
| mar_in | input | 1 | Address register captures bus |
| mdr_in | input | 1 | Data register captures bus |
| mdr_out | input | 1 | Data register drives bus |
| ir_in | input | 1 | Instruction register captures bus |
| r_in | input | NGP | General register k captures bus |
| r_out | input | NGP | General register k drives bus |
| y_in | input | 1 | Y latch captures bus |
| clr_y | input | 1 | Force adder first operand to zero |
| cin | input | 1 | Adder carry-in |
| add_en | input | 1 | Adder adds (else passes bus) |
| z_in | input | 1 | Z captures adder result |
| z_out | input | 1 | Z drives bus |
| rd | input | 1 | Read request from controller |
| mem_done | input | 1 | Memory completion strobe |
| mem_rdata | input | DW | Data returned by memory |
| mem_rd_o | output | 1 | Read request to memory |
| mem_addr_o | output | DW | Memory address (address register) |
| mem_mdr_o | output | DW | Memory data register contents |
| pc_o | output | DW | Program counter contents |
| ir_o | output | DW | Instruction register contents |
| bus_o | output | DW | Internal bus value |

## Verification
The bench targets several corner cases, each with a distinct failure.

- **PC increment at 16'hFFFF.** A design that carried into a wider Z, or ignored clr_y, would leave a wrong program counter.
- **mem_done and mdr_in in the same cycle.** Reversed priority would load the bus value instead of the memory word.
- **Read left pending without mem_done.** A design that loaded on rd would corrupt the data register.
- **Idle bus and pass-through Z.** With no driver selected the bus must read zero. With add_en low Z must hold exactly the bus value, so stale drivers or a stray carry show up at once.
- **Full sequence.** A fetch followed by a register-plus-memory add runs end to end. Random strobe patterns are compared against a bench model every cycle.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    // number of general-purpose registers on the bus
    parameter int unsigned NREG = 3;
    // bus source slots: PC, MDR, general registers, Z
    parameter int unsigned SRC_PC  = 0;
    parameter int unsigned SRC_MDR = 1;
    parameter int unsigned SRC_GP0 = 2;
endpackage

// File: rtl/sbd_bus_mux.sv
module sbd_bus_mux #(
    parameter int N = 6,
    parameter int W = 16
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);
    logic [N-1:0][W-1:0] masked;

    for (genvar i = 0; i < N; i++) begin : g_mask
        assign masked[i] = sel[i] ? src[i] : '0;
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | masked[i];
        end
    end
endmodule

// File: rtl/sbd_alu.sv
module sbd_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         clr_a,
    input  logic         cin,
    input  logic         add_en,
    output logic [W-1:0] res
);
    logic [W-1:0] a_eff;

    assign a_eff = clr_a ? '0 : opa;
    assign res   = add_en ? (a_eff + opb + {{(W-1){1'b0}}, cin}) : opb;
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
    parameter int DW  = 16,
    parameter int NGP = sbd_pkg::NREG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pc_in,
    input  logic           pc_out,
    input  logic           mar_in,
    input  logic           mdr_in,
    input  logic           mdr_out,
    input  logic           ir_in,
    input  logic [NGP-1:0] r_in,
    input  logic [NGP-1:0] r_out,
    input  logic           y_in,
    input  logic           clr_y,
    input  logic           cin,
    input  logic           add_en,
    input  logic           z_in,
    input  logic           z_out,
    input  logic           rd,
    input  logic           mem_done,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_rd_o,
    output logic [DW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_mdr_o,
    output logic [DW-1:0]  pc_o,
    output logic [DW-1:0]  ir_o,
    output logic [DW-1:0]  bus_o
);
    localparam int NSRC    = NGP + 3;
    localparam int SRC_Z   = NSRC - 1;

    typedef struct packed {
        logic [DW-1:0]           pc;
        logic [DW-1:0]           mar;
        logic [DW-1:0]           mdr;
        logic [DW-1:0]           ir;
        logic [DW-1:0]           y;
        logic [DW-1:0]           z;
        logic [NGP-1:0][DW-1:0]  r;
    } dp_state_t;

    dp_state_t st_q, st_d;

    logic [NSRC-1:0]          drv_sel;
    logic [NSRC-1:0][DW-1:0]  drv_src;
    logic [DW-1:0]            bus;
    logic [DW-1:0]            alu_res;

    assign drv_sel[sbd_pkg::SRC_PC]  = pc_out;
    assign drv_src[sbd_pkg::SRC_PC]  = st_q.pc;
    assign drv_sel[sbd_pkg::SRC_MDR] = mdr_out;
    assign drv_src[sbd_pkg::SRC_MDR] = st_q.mdr;
    for (genvar g = 0; g < NGP; g++) begin : g_gp_src
        assign drv_sel[sbd_pkg::SRC_GP0 + g] = r_out[g];
        assign drv_src[sbd_pkg::SRC_GP0 + g] = st_q.r[g];
    end
    assign drv_sel[SRC_Z] = z_out;
    assign drv_src[SRC_Z] = st_q.z;

    sbd_bus_mux #(.N(NSRC), .W(DW)) u_mux (
        .sel (drv_sel),
        .src (drv_src),
        .bus (bus)
    );

    sbd_alu #(.W(DW)) u_alu (
        .opa    (st_q.y),
        .opb    (bus),
        .clr_a  (clr_y),
        .cin    (cin),
        .add_en (add_en),
        .res    (alu_res)
    );

    always_comb begin
        st_d = st_q;
        if (pc_in)  st_d.pc  = bus;
        if (mar_in) st_d.mar = bus;
        if (ir_in)  st_d.ir  = bus;
        if (y_in)   st_d.y   = bus;
        if (z_in)   st_d.z   = alu_res;
        for (int k = 0; k < NGP; k++) begin
            if (r_in[k]) st_d.r[k] = bus;
        end
        // memory completion has priority over a bus write
        if (mem_done)    st_d.mdr = mem_rdata;
        else if (mdr_in) st_d.mdr = bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_rd_o   = rd;
    assign mem_addr_o = st_q.mar;
    assign mem_mdr_o  = st_q.mdr;
    assign pc_o       = st_q.pc;
    assign ir_o       = st_q.ir;
    assign bus_o      = bus;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
    parameter int DW  = 16,
    parameter int NGP = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pc_in,
    input logic           pc_out,
    input logic           mar_in,
    input logic           mdr_in,
    input logic           mdr_out,
    input logic [NGP-1:0] r_out,
    input logic           z_out,
    input logic           rd,
    input logic           mem_done,
    input logic [DW-1:0]  mem_rdata,
    input logic           mem_rd_o,
    input logic [DW-1:0]  mem_addr_o,
    input logic [DW-1:0]  mem_mdr_o,
    input logic [DW-1:0]  pc_o,
    input logic [DW-1:0]  bus_o
);
    logic [NGP+2:0] outs;
    assign outs = {z_out, r_out, mdr_out, pc_out};

    // R2: at most one bus driver
    p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(outs));

    // R2: idle bus reads zero
    p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (outs == '0) |-> (bus_o == '0));

    // R3: PC holds without its in strobe
    p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_in |=> $stable(pc_o));

    // R3: PC captures bus with its in strobe
    p_pc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_in |=> (pc_o == $past(bus_o)));

    // R7: address register changes only on mar_in
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mar_in |=> $stable(mem_addr_o));

    // R7: read request passes through
    p_rd_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o == rd);

    // R8 / R9: completion loads memory data
    p_mdr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |=> (mem_mdr_o == $past(mem_rdata)));

    // R8: data register idle without completion or bus write
    p_mdr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_done && !mdr_in) |=> $stable(mem_mdr_o));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DW(DW), .NGP(NGP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_in      (pc_in),
    .pc_out     (pc_out),
    .mar_in     (mar_in),
    .mdr_in     (mdr_in),
    .mdr_out    (mdr_out),
    .r_out      (r_out),
    .z_out      (z_out),
    .rd         (rd),
    .mem_done   (mem_done),
    .mem_rdata  (mem_rdata),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .mem_mdr_o  (mem_mdr_o),
    .pc_o       (pc_o),
    .bus_o      (bus_o)
);

// File: tb/sbus_datapath_bench.sv
module sbus_datapath_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic pc_in, pc_out, mar_in, mdr_in, mdr_out, ir_in;
    logic [2:0] r_in, r_out;
    logic y_in, clr_y, cin, add_en, z_in, z_out, rd, mem_done;
    logic [W-1:0] mem_rdata;
    logic mem_rd_o;
    logic [W-1:0] mem_addr_o, mem_mdr_o, pc_o, ir_o, bus_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model
    logic [W-1:0] m_pc, m_mar, m_mdr, m_ir, m_y, m_z;
    logic [W-1:0] m_r [3];

    always #2 clk = ~clk;

    sbus_datapath u_sbus_datapath (
        .clk(clk), .rst_n(rst_n),
        .pc_in(pc_in), .pc_out(pc_out), .mar_in(mar_in), .mdr_in(mdr_in),
        .mdr_out(mdr_out), .ir_in(ir_in), .r_in(r_in), .r_out(r_out),
        .y_in(y_in), .clr_y(clr_y), .cin(cin), .add_en(add_en),
        .z_in(z_in), .z_out(z_out), .rd(rd), .mem_done(mem_done),
        .mem_rdata(mem_rdata), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_mdr_o(mem_mdr_o), .pc_o(pc_o), .ir_o(ir_o), .bus_o(bus_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pc_in = 0; pc_out = 0; mar_in = 0; mdr_in = 0; mdr_out = 0; ir_in = 0;
        r_in = '0; r_out = '0; y_in = 0; clr_y = 0; cin = 0; add_en = 0;
        z_in = 0; z_out = 0; rd = 0; mem_done = 0; mem_rdata = '0;
    endtask

    function automatic logic [W-1:0] exp_bus();
        logic [W-1:0] b = '0;
        if (pc_out)   b = m_pc;
        if (mdr_out)  b = m_mdr;
        for (int k = 0; k < 3; k++) if (r_out[k]) b = m_r[k];
        if (z_out)    b = m_z;
        return b;
    endfunction

    function automatic logic [W-1:0] exp_alu(input logic [W-1:0] b);
        logic [W-1:0] a = clr_y ? '0 : m_y;
        return add_en ? W'(a + b + W'(cin)) : b;
    endfunction

    // one clock step: strobes already driven after a falling edge
    task automatic tick();
        logic [W-1:0] eb;
        #1;
        eb = exp_bus();
        chk(bus_o == eb, "R2 bus", bus_o, eb);
        chk(mem_rd_o == rd, "R7 rd", W'(mem_rd_o), W'(rd));
        if (z_in)   m_z  = exp_alu(eb);
        if (pc_in)  m_pc = eb;
        if (mar_in) m_mar = eb;
        if (ir_in)  m_ir = eb;
        if (y_in)   m_y  = eb;
        for (int k = 0; k < 3; k++) if (r_in[k]) m_r[k] = eb;
        if (mem_done)    m_mdr = mem_rdata;
        else if (mdr_in) m_mdr = eb;
        @(negedge clk);
        chk(pc_o == m_pc, "R3 pc", pc_o, m_pc);
        chk(ir_o == m_ir, "R3 ir", ir_o, m_ir);
        chk(mem_addr_o == m_mar, "R7 addr", mem_addr_o, m_mar);
        chk(mem_mdr_o == m_mdr, "R8 mdr", mem_mdr_o, m_mdr);
        idle();
    endtask

    task automatic peek_bus(input string tag, input logic [W-1:0] exp);
        #1;
        chk(bus_o == exp, tag, bus_o, exp);
        @(negedge clk);
    endtask

    // load a value into the data register from memory
    task automatic mem_load(input logic [W-1:0] v);
        mem_done = 1; mem_rdata = v; tick();
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20021011));
        idle();
        rst_n = 0;
        m_pc = '0; m_mar = '0; m_mdr = '0; m_ir = '0; m_y = '0; m_z = '0;
        for (int k = 0; k < 3; k++) m_r[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(pc_o == 0, "R1 pc", pc_o, 0);
        chk(ir_o == 0, "R1 ir", ir_o, 0);
        chk(mem_addr_o == 0, "R1 addr", mem_addr_o, 0);
        chk(mem_mdr_o == 0, "R1 mdr", mem_mdr_o, 0);
        chk(bus_o == 0, "R1 bus", bus_o, 0);

        // set R1 = 10, R3 = 5
        mem_load(16'd10); mdr_out = 1; r_in = 3'b001; tick();
        mem_load(16'd5);  mdr_out = 1; r_in = 3'b100; tick();

        // fetch: PC to MAR, read, Z = PC+1
        pc_out = 1; mar_in = 1; rd = 1; clr_y = 1; cin = 1; add_en = 1; z_in = 1; tick();
        z_out = 1; pc_in = 1; mem_done = 1; mem_rdata = 16'h1234; tick();
        mdr_out = 1; ir_in = 1; tick();
        chk(ir_o == 16'h1234, "R8 fetched instruction", ir_o, 16'h1234);
        chk(pc_o == 16'd1, "R5 pc incremented", pc_o, 16'd1);
        // add: R1 <- R1 + mem[R3]
        r_out = 3'b100; mar_in = 1; rd = 1; tick();
        chk(mem_addr_o == 16'd5, "R7 operand address", mem_addr_o, 16'd5);
        r_out = 3'b001; y_in = 1; mem_done = 1; mem_rdata = 16'd7; tick();
        mdr_out = 1; add_en = 1; z_in = 1; tick();
        z_out = 1; r_in = 3'b001; tick();
        r_out = 3'b001; peek_bus("R4 sum in R1", 16'd17);
        idle();

        // R5 wraparound: PC = FFFF then increment
        mem_load(16'hFFFF); mdr_out = 1; pc_in = 1; tick();
        pc_out = 1; clr_y = 1; cin = 1; add_en = 1; z_in = 1; tick();
        z_out = 1; pc_in = 1; tick();
        chk(pc_o == 16'h0000, "R5 wrap", pc_o, 16'h0000);

        // R6 pass-through with add low, Y non-zero, cin high
        mem_load(16'h00A5); mdr_out = 1; y_in = 1; tick();
        r_out = 3'b010; cin = 1; z_in = 1; tick();
        z_out = 1; peek_bus("R6 pass", m_r[1]);
        idle();
        // R6 Z holds when z_in low
        pc_out = 1; add_en = 1; tick();
        z_out = 1; peek_bus("R6 hold", m_r[1]);
        idle();

        // R8 pending read without completion leaves MDR
        mem_load(16'h5A5A);
        rd = 1; mem_rdata = 16'h1111; tick();
        chk(mem_mdr_o == 16'h5A5A, "R8 no done", mem_mdr_o, 16'h5A5A);

        // R9 completion beats bus write
        pc_out = 1; mdr_in = 1; mem_done = 1; mem_rdata = 16'hBEEF; tick();
        chk(mem_mdr_o == 16'hBEEF, "R9 priority", mem_mdr_o, 16'hBEEF);
        // R2 idle bus zero
        peek_bus("R2 idle", 16'h0000);

        // random strobe patterns
        for (int n = 0; n < 2000; n++) begin
            int o;
            o = $urandom_range(0, 6);
            pc_out  = (o == 1);
            mdr_out = (o == 2);
            r_out   = (o >= 3 && o <= 5) ? 3'(1 << (o - 3)) : 3'b000;
            z_out   = (o == 6);
            pc_in   = ($urandom_range(0, 3) == 0);
            mar_in  = ($urandom_range(0, 2) == 0);
            mdr_in  = ($urandom_range(0, 3) == 0);
            ir_in   = ($urandom_range(0, 3) == 0);
            r_in    = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
            y_in    = ($urandom_range(0, 2) == 0);
            clr_y   = $urandom_range(0, 1);
            cin     = $urandom_range(0, 1);
            add_en  = $urandom_range(0, 1);
            z_in    = $urandom_range(0, 1);
            rd      = $urandom_range(0, 1);
            mem_done = ($urandom_range(0, 3) == 0);
            mem_rdata = W'($urandom);
            tick();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule